// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash bus. It runs the three state-changing flash operations: writing one byte, erasing one sector and erasing the whole device. A single-cycle request carries the operation code, the target address and, for a program, the byte to store. The controller then drives the flash through the unlock command writes that the operation needs. Each write has a setup phase, a write-enable low pulse and a recovery phase, and the length of each phase is derived from nanosecond parameters and the clock frequency.

After the final command write the controller reads the target address again and again and watches data bit 7. The device returns the inverse of the expected bit 7 while its internal algorithm runs. When bit 7 matches, the operation has finished. A timeout counter bounds the polling. Its limit comes from the worst-case program time or erase time, converted to clocks. If the counter expires first, the controller writes a single reset command to put the device back into read mode, then reports completion together with an error flag.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset busy_o, done_o, err_o and fl_dq_oe_o are 0, and fl_ce_no, fl_we_no and fl_oe_no are 1.
- R2: Program (cmd_i = 2'b00) issues exactly four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (target address, target data).
- R3: Sector erase (cmd_i = 2'b01) issues exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (target address, 30h).
- R4: Chip erase (cmd_i = 2'b10) issues the same first five writes as sector erase, and its sixth write is (5555h, 10h).
- R5: Every write-enable low pulse lasts exactly WE_LOW_CYC clocks. During the pulse the data is driven and does not change. Write-enable stays high for at least WE_HIGH_CYC clocks between two pulses.
- R6: After the last command write, output-enable stays high for at least OE_HOLD_CYC clocks before the first polling read. Each polling read holds output-enable low for exactly RD_CYC clocks.
- R7: Polling reads the target address until data bit 7 equals the expected bit, which is bit 7 of the program data, or 1 for either erase. The number of reads equals the index of the first matching read, and no read follows the match.
- R8: If the timeout expires with bit 7 still wrong, exactly one further write (5555h, F0h) is issued, and done_o then pulses with err_o = 1. A successful operation ends with err_o = 0.
- R9: done_o is high for one clock per operation. busy_o is low in that clock and high in the clock before it.
- R10: A request while busy_o is high is ignored. A request with cmd_i = 2'b11 is ignored: it causes no bus write and busy_o stays low.
- R11: Write-enable and output-enable are never low together. The data bus is driven only while output-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, accepted when busy_o is low |
| cmd_i | input | 2 | 00 program, 01 sector erase, 10 chip erase |
| addr_i | input | AW | Target byte or sector address |
| data_i | input | 8 | Byte to program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | 8 | Flash read data |
| fl_ce_no | output | 1 | Chip enable, active low |
| fl_we_no | output | 1 | Write enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |

## Verification
The assertions assume that reset is held long enough to start every counter from zero. They also assume that the flash data input is stable for the whole read access window, because only the value present at the last access clock is used. The bench flash model meets this. It changes its read data only at the falling edge of output-enable, it decides from the read count whether the bit 7 value is the completed one or the in-progress one, and it raises req_i only away from clock edges.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RST  = 2'd3
  } op_e;

  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLK_DAT_A  = 8'hAA;
  localparam logic [7:0]  UNLK_DAT_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;

  function automatic int ns2cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_ctrl_pkg::*;
#(
  parameter int AW = 21
) (
  input  op_e             op_i,
  input  logic [2:0]      idx_i,
  input  logic [AW-1:0]   tgt_addr_i,
  input  logic [7:0]      tgt_data_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [7:0]      wr_data_o,
  output logic            last_o
);
  localparam logic [AW-1:0] ADDR_A = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLK_ADDR_B);

  always_comb begin
    wr_addr_o = ADDR_A;
    wr_data_o = UNLK_DAT_A;
    last_o    = 1'b0;
    unique case (op_i)
      OP_PROG: begin
        unique case (idx_i)
          3'd0: ;
          3'd1: begin wr_addr_o = ADDR_B; wr_data_o = UNLK_DAT_B; end
          3'd2: wr_data_o = CMD_PROG;
          default: begin
            wr_addr_o = tgt_addr_i;
            wr_data_o = tgt_data_i;
            last_o    = 1'b1;
          end
        endcase
      end
      OP_SECT, OP_CHIP: begin
        unique case (idx_i)
          3'd0, 3'd3: ;
          3'd1, 3'd4: begin wr_addr_o = ADDR_B; wr_data_o = UNLK_DAT_B; end
          3'd2: wr_data_o = CMD_ERASE;
          default: begin
            last_o = 1'b1;
            if (op_i == OP_CHIP) begin
              wr_data_o = CMD_CHIP;
            end else begin
              wr_addr_o = tgt_addr_i;
              wr_data_o = CMD_SECT;
            end
          end
        endcase
      end
      default: begin
        wr_data_o = CMD_RESET;
        last_o    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
  parameter int AW          = 21,
  parameter int WE_LOW_CYC  = 12,
  parameter int WE_HIGH_CYC = 5,
  parameter int OE_HOLD_CYC = 3,
  parameter int RD_CYC      = 23
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          read_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          done_o,
  output logic [7:0]    rd_data_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int MAX_AB = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAX_CD = (OE_HOLD_CYC > RD_CYC) ? OE_HOLD_CYC : RD_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {B_IDLE, B_WSET, B_WLOW, B_WREC, B_RGAP, B_RACC} bst_e;

  bst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    dq_q;
  logic [7:0]    rd_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= B_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      dq_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        B_IDLE: if (start_i) begin
          addr_q <= addr_i;
          dq_q   <= data_i;
          if (read_i) begin
            st_q  <= B_RGAP;
            cnt_q <= CW'(OE_HOLD_CYC - 1);
          end else begin
            st_q  <= B_WSET;
            cnt_q <= '0;
          end
        end
        B_WSET: begin
          st_q  <= B_WLOW;
          cnt_q <= CW'(WE_LOW_CYC - 1);
        end
        B_WLOW: if (cnt_q == '0) begin
          st_q  <= B_WREC;
          cnt_q <= CW'(WE_HIGH_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        B_WREC: if (cnt_q == '0) begin
          st_q   <= B_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        B_RGAP: if (cnt_q == '0) begin
          st_q  <= B_RACC;
          cnt_q <= CW'(RD_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        B_RACC: if (cnt_q == '0) begin
          st_q   <= B_IDLE;
          done_q <= 1'b1;
          rd_q   <= fl_dq_i;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign rd_data_o  = rd_q;
  assign fl_addr_o  = addr_q;
  assign fl_dq_o    = dq_q;
  assign fl_dq_oe_o = (st_q == B_WSET) || (st_q == B_WLOW) || (st_q == B_WREC);
  assign fl_ce_no   = (st_q == B_IDLE);
  assign fl_we_no   = (st_q != B_WLOW);
  assign fl_oe_no   = (st_q != B_RACC);

endmodule

// File: rtl/flash_tmo.sv
module flash_tmo #(
  parameter int TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int AW           = 21,
  parameter int CLK_MHZ      = 250,
  parameter int WE_LOW_NS    = 45,
  parameter int WE_HIGH_NS   = 20,
  parameter int OE_HOLD_NS   = 10,
  parameter int RD_ACC_NS    = 90,
  parameter int PROG_TMO_US  = 300,
  parameter int ERASE_TMO_MS = 15000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [7:0]    fl_dq_i,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no
);
  localparam int WE_LOW_CYC  = ns2cyc(WE_LOW_NS, CLK_MHZ);
  localparam int WE_HIGH_CYC = ns2cyc(WE_HIGH_NS, CLK_MHZ);
  localparam int OE_HOLD_CYC = ns2cyc(OE_HOLD_NS, CLK_MHZ);
  localparam int RD_CYC      = ns2cyc(RD_ACC_NS, CLK_MHZ);
  localparam longint unsigned PROG_TMO_CYC  = longint'(PROG_TMO_US) * longint'(CLK_MHZ);
  localparam longint unsigned ERASE_TMO_CYC = longint'(ERASE_TMO_MS) * 1000 * longint'(CLK_MHZ);
  localparam longint unsigned MAX_TMO = (PROG_TMO_CYC > ERASE_TMO_CYC) ? PROG_TMO_CYC : ERASE_TMO_CYC;
  localparam int TW = $clog2(MAX_TMO + 1);

  typedef enum logic [1:0] {T_IDLE, T_WR, T_POLL} tst_e;

  tst_e          st_q;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [2:0]    idx_q;
  logic          read_q;
  logic          launch_q;
  logic          done_q;
  logic          err_q;

  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_data;
  logic          seq_last;
  logic          bus_done;
  logic [7:0]    bus_rd;
  logic          tmo_exp;
  logic          exp_bit;
  logic [TW-1:0] tmo_limit;
  logic          unused_rd;

  flash_cmd_seq #(.AW(AW)) u_seq (
    .op_i       (op_q),
    .idx_i      (idx_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .wr_addr_o  (seq_addr),
    .wr_data_o  (seq_data),
    .last_o     (seq_last)
  );

  flash_bus_cycle #(
    .AW          (AW),
    .WE_LOW_CYC  (WE_LOW_CYC),
    .WE_HIGH_CYC (WE_HIGH_CYC),
    .OE_HOLD_CYC (OE_HOLD_CYC),
    .RD_CYC      (RD_CYC)
  ) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (launch_q),
    .read_i     (read_q),
    .addr_i     (read_q ? addr_q : seq_addr),
    .data_i     (seq_data),
    .done_o     (bus_done),
    .rd_data_o  (bus_rd),
    .fl_addr_o  (fl_addr_o),
    .fl_dq_o    (fl_dq_o),
    .fl_dq_oe_o (fl_dq_oe_o),
    .fl_dq_i    (fl_dq_i),
    .fl_ce_no   (fl_ce_no),
    .fl_we_no   (fl_we_no),
    .fl_oe_no   (fl_oe_no)
  );

  assign tmo_limit = (op_q == OP_PROG) ? TW'(PROG_TMO_CYC) : TW'(ERASE_TMO_CYC);

  flash_tmo #(.TW(TW)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (st_q == T_WR),
    .run_i     (st_q == T_POLL),
    .limit_i   (tmo_limit),
    .expired_o (tmo_exp)
  );

  // erase leaves the cell at all ones
  assign exp_bit   = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign unused_rd = ^bus_rd[6:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= T_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      idx_q    <= '0;
      read_q   <= 1'b0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      unique case (st_q)
        T_IDLE: if (req_i && cmd_i != 2'b11) begin
          op_q     <= op_e'(cmd_i);
          addr_q   <= addr_i;
          data_q   <= data_i;
          idx_q    <= '0;
          read_q   <= 1'b0;
          launch_q <= 1'b1;
          st_q     <= T_WR;
        end
        T_WR: if (bus_done) begin
          if (!seq_last) begin
            idx_q    <= idx_q + 1'b1;
            launch_q <= 1'b1;
          end else if (op_q == OP_RST) begin
            st_q   <= T_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            st_q     <= T_POLL;
            read_q   <= 1'b1;
            launch_q <= 1'b1;
          end
        end
        T_POLL: if (bus_done) begin
          if (bus_rd[7] == exp_bit) begin
            st_q   <= T_IDLE;
            done_q <= 1'b1;
            read_q <= 1'b0;
          end else if (tmo_exp) begin
            op_q     <= OP_RST;
            idx_q    <= '0;
            read_q   <= 1'b0;
            launch_q <= 1'b1;
            st_q     <= T_WR;
          end else begin
            launch_q <= 1'b1;
          end
        end
        default: st_q <= T_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != T_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk #(
  parameter int WE_LOW_CYC = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic fl_dq_oe_o,
  input logic fl_ce_no,
  input logic fl_we_no,
  input logic fl_oe_no
);
  logic [15:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lo_cnt <= '0;
    else if (fl_we_no)       lo_cnt <= '0;
    else if (lo_cnt != '1)   lo_cnt <= lo_cnt + 1'b1;
  end

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r11_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> fl_oe_no);

  a_r11_drive_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_dq_oe_o |-> fl_oe_no);

  a_r5_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no) |-> (lo_cnt == 16'(WE_LOW_CYC)));

  a_r1_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fl_ce_no && fl_we_no && fl_oe_no));

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.WE_LOW_CYC(WE_LOW_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .fl_dq_oe_o (fl_dq_oe_o),
  .fl_ce_no   (fl_ce_no),
  .fl_we_no   (fl_we_no),
  .fl_oe_no   (fl_oe_no)
);

// File: tb/flash_prog_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb_top;
  localparam int AW = 21;
  localparam int WE_LOW  = 3;   // 12 ns at 250 MHz
  localparam int WE_HIGH = 2;   // 8 ns
  localparam int OE_HOLD = 2;   // 8 ns
  localparam int RD      = 3;   // 12 ns

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [1:0] cmd_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic busy_o, done_o, err_o, fl_dq_oe_o, fl_ce_no, fl_we_no, fl_oe_no;
  logic [AW-1:0] fl_addr_o;
  logic [7:0] fl_dq_o, fl_dq_i;

  always #2 clk_i = ~clk_i;

  flash_prog_ctrl #(
    .AW(AW), .CLK_MHZ(250), .WE_LOW_NS(12), .WE_HIGH_NS(8), .OE_HOLD_NS(8),
    .RD_ACC_NS(12), .PROG_TMO_US(1), .ERASE_TMO_MS(1)
  ) dut_i (.*);

  int checks = 0, errors = 0;
  int cyc = 0;

  // flash model and bus monitor
  int ready_at = 1;
  logic [7:0] good_val = '0;
  int rd_cnt, nlog, done_cnt, last_rise, first_gap, min_gap, min_low, max_low, min_rd, max_rd;
  int cur_low, cur_rd;
  logic done_err, done_busy, prev_busy_at_done, dq_bad, prev_we = 1, prev_oe = 1, prev_busy = 0;
  logic [7:0] cur_dq;
  logic [AW-1:0] la [16];
  logic [7:0] ld [16];

  assign fl_dq_i = (rd_cnt >= ready_at) ? good_val : (good_val ^ 8'hC0);

  task automatic clear_mon();
    rd_cnt = 0; nlog = 0; done_cnt = 0; last_rise = -1; first_gap = -1;
    min_gap = 1000; min_low = 1000; max_low = 0; min_rd = 1000; max_rd = 0;
    dq_bad = 0; done_err = 0; done_busy = 0; prev_busy_at_done = 0;
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (prev_we && !fl_we_no) begin
      cur_low = 0; cur_dq = fl_dq_o;
      if (last_rise >= 0 && cyc - last_rise < min_gap) min_gap = cyc - last_rise;
    end
    if (!fl_we_no) begin
      cur_low++;
      if (fl_dq_o !== cur_dq || !fl_dq_oe_o) dq_bad = 1;
    end
    if (!prev_we && fl_we_no) begin
      if (nlog < 16) begin la[nlog] = fl_addr_o; ld[nlog] = fl_dq_o; end
      nlog++;
      last_rise = cyc;
      if (cur_low < min_low) min_low = cur_low;
      if (cur_low > max_low) max_low = cur_low;
    end
    if (prev_oe && !fl_oe_no) begin
      rd_cnt++; cur_rd = 0;
      if (first_gap < 0) first_gap = cyc - last_rise;
    end
    if (!fl_oe_no) cur_rd++;
    if (!prev_oe && fl_oe_no) begin
      if (cur_rd < min_rd) min_rd = cur_rd;
      if (cur_rd > max_rd) max_rd = cur_rd;
    end
    if (done_o) begin
      done_cnt++; done_err = err_o; done_busy = busy_o; prev_busy_at_done = prev_busy;
    end
    if (fl_dq_oe_o && !fl_oe_no) dq_bad = 1;
    prev_we = fl_we_no; prev_oe = fl_oe_no; prev_busy = busy_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected write list built from the requirements
  task automatic check_log(input string req, input logic [1:0] cmd, input logic [AW-1:0] a,
                           input logic [7:0] d, input bit with_rst);
    logic [AW-1:0] ea [8];
    logic [7:0] ed [8];
    int n;
    ea[0] = 21'h05555; ed[0] = 8'hAA;
    ea[1] = 21'h02AAA; ed[1] = 8'h55;
    if (cmd == 2'b00) begin
      ea[2] = 21'h05555; ed[2] = 8'hA0;
      ea[3] = a;         ed[3] = d;
      n = 4;
    end else begin
      ea[2] = 21'h05555; ed[2] = 8'h80;
      ea[3] = 21'h05555; ed[3] = 8'hAA;
      ea[4] = 21'h02AAA; ed[4] = 8'h55;
      if (cmd == 2'b01) begin ea[5] = a; ed[5] = 8'h30; end
      else begin ea[5] = 21'h05555; ed[5] = 8'h10; end
      n = 6;
    end
    if (with_rst) begin ea[n] = 21'h05555; ed[n] = 8'hF0; n++; end
    chk(nlog == n, req, "write count", nlog, n);
    for (int i = 0; i < n && i < nlog; i++)
      chk(la[i] == ea[i] && ld[i] == ed[i], req, $sformatf("write %0d", i),
          {la[i], ld[i]}, {ea[i], ed[i]});
  endtask

  task automatic start_op(input logic [1:0] cmd, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cmd_i = cmd; addr_i = a; data_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !err_o && !fl_dq_oe_o, "R1", "status idle",
        {busy_o, done_o, err_o, fl_dq_oe_o}, 0);
    chk(fl_ce_no && fl_we_no && fl_oe_no, "R1", "bus strobes high",
        {fl_ce_no, fl_we_no, fl_oe_no}, 3'b111);
  endtask

  task automatic t_program(input logic [7:0] d, input int ready);
    clear_mon(); ready_at = ready; good_val = d;
    start_op(2'b00, 21'h1ABCD, d);
    wait_done();
    check_log("R2", 2'b00, 21'h1ABCD, d, 0);
    chk(min_low == WE_LOW && max_low == WE_LOW, "R5", "we low width", max_low, WE_LOW);
    chk(min_gap >= WE_HIGH, "R5", "we high gap", min_gap, WE_HIGH);
    chk(!dq_bad, "R5_R11", "data stable, driven only with oe high", dq_bad, 0);
    chk(first_gap > OE_HOLD, "R6", "oe hold after last write", first_gap, OE_HOLD + 1);
    chk(min_rd == RD && max_rd == RD, "R6", "read width", max_rd, RD);
    chk(rd_cnt == ready, "R7", "poll reads", rd_cnt, ready);
    chk(done_cnt == 1 && !done_err, "R8", "done ok no err", {done_cnt, done_err}, 2);
    chk(!done_busy && prev_busy_at_done, "R9", "busy around done", {done_busy, prev_busy_at_done}, 1);
  endtask

  task automatic t_erase(input logic [1:0] cmd, input int ready);
    clear_mon(); ready_at = ready; good_val = 8'hFF;
    start_op(cmd, 21'h170000, 8'h00);
    wait_done();
    check_log(cmd == 2'b01 ? "R3" : "R4", cmd, 21'h170000, 8'h00, 0);
    chk(rd_cnt == ready, "R7", "erase poll reads", rd_cnt, ready);
    chk(done_cnt == 1 && !done_err, "R9", "erase done pulse", done_cnt, 1);
  endtask

  task automatic t_timeout();
    clear_mon(); ready_at = 1000000; good_val = 8'h5A;
    start_op(2'b00, 21'h00042, 8'h5A);
    wait_done();
    check_log("R8", 2'b00, 21'h00042, 8'h5A, 1);
    chk(done_cnt == 1 && done_err, "R8", "err with done", {done_cnt, done_err}, 3);
    chk(rd_cnt > 1, "R8", "polled before timeout", rd_cnt, 2);
  endtask

  task automatic t_busy_ignore();
    clear_mon(); ready_at = 2; good_val = 8'h81;
    start_op(2'b00, 21'h00100, 8'h81);
    repeat (6) @(negedge clk_i);
    start_op(2'b01, 21'h010000, 8'h00);
    wait_done();
    check_log("R10", 2'b00, 21'h00100, 8'h81, 0);
    chk(done_cnt == 1, "R10", "single done", done_cnt, 1);
  endtask

  task automatic t_bad_cmd();
    clear_mon();
    start_op(2'b11, 21'h00000, 8'h00);
    repeat (20) begin
      @(negedge clk_i);
      if (busy_o) dq_bad = 1;
    end
    chk(nlog == 0 && !dq_bad, "R10", "cmd 11 ignored", nlog, 0);
  endtask

  bit finished = 0;
  initial begin
    clear_mon();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_program(8'hC3, 3);
    t_program(8'h35, 1);
    t_erase(2'b01, 2);
    t_erase(2'b10, 4);
    t_timeout();
    t_busy_ignore();
    t_bad_cmd();
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !finished; i++) @(negedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule